// File: doc/BRIEF.md
# Legacy PC System Control Port

This block is the motherboard glue logic that sits around a three-port parallel I/O device in an early personal computer. The CPU writes an 8-bit control byte (port B). The bits of this byte drive the timer-2 gate and the speaker data line. They also select what the CPU reads back on the two input ports, clear the keyboard receiver, hold the keyboard clock line low, and enable or mask reporting of RAM parity errors.

The block contains a small keyboard serial receiver. It samples the keyboard data line on falling keyboard-clock edges, assembles one byte and raises IRQ1. Two sticky parity-error latches are also inside. Port A returns either the received keyboard byte or the primary switch block, and port C returns a switch nibble together with status bits.

The parameter `EARLY_LAYOUT` picks between two board layouts:
- With `EARLY_LAYOUT = 1`, a second switch block is present and the primary switches can be shown on port A.
- With `EARLY_LAYOUT = 0`, port A always returns the keyboard byte and port C shows either nibble of the primary switches.

The timer, the speaker driver, the parity generators and the keyboard itself are outside the block. They connect through plain signals.

Top module: `pc_sysctl_port`

## Requirements
- R1: After reset the control byte is 0x00. This means irq1 is 0, tmr2_gate and spkr_data are 0, kbd_clk_hold is 1, and both parity flags (port C bits 7 and 6) are 0.
- R2: Register select encoding on `sel` is 0 = port A, 1 = port B, 2 = port C and 3 = returns 0x00. Writing with wr_en and sel = 1 loads the control byte on the next clock edge. Port B reads back the last written byte. Control bit 0 drives tmr2_gate and bit 1 drives spkr_data.
- R3: Port C bit 5 mirrors tmr2_out and port C bit 4 mirrors spkr_mon.
- R4: With EARLY_LAYOUT = 0, port A always returns the received keyboard byte. Port C bits 3..0 show sw1[7:4] when control bit 3 is 1, and sw1[3:0] when it is 0 (sw1[0] is switch 1).
- R5: With EARLY_LAYOUT = 1, port A returns sw1 when control bit 7 is 1 and the keyboard byte otherwise. Port C bits 3..0 show sw2[3:0] when control bit 2 is 1, and {1,1,1,sw2[4]} when it is 0 (sw2[0] is switch 1, sw2[4] is switch 5).
- R6: kbd_clk_hold is 1 whenever control bit 6 is 0 or irq1 is 1.
- R7: The receiver waits idle for a falling keyboard-clock edge with data = 1 (the start bit). It then takes 8 data bits LSB first on the next 8 falling edges. After the last one the byte appears on port A and irq1 becomes 1.
- R8: While irq1 is 1, further keyboard-clock edges are ignored and the held byte does not change.
- R9: While control bit 7 is 1, the receiver is held idle, irq1 is 0 and the keyboard byte reads 0x00.
- R10: A parity strobe sets its sticky flag only while its enable bit is 0; a strobe with the enable bit at 1 is ignored. The flag clears when the enable bit is 1. The mapping is: motherboard strobe → control bit 4 → port C bit 7, and expansion strobe → control bit 5 → port C bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Port select for read and write |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected port |
| sw1 | input | 8 | Primary configuration switches |
| sw2 | input | 5 | Secondary configuration switches |
| tmr2_out | input | 1 | Timer channel 2 output |
| spkr_mon | input | 1 | Speaker signal monitor |
| par_err_mb | input | 1 | Motherboard parity error strobe |
| par_err_io | input | 1 | Expansion-card parity error strobe |
| kbd_clk_i | input | 1 | Keyboard clock line |
| kbd_data_i | input | 1 | Keyboard data line |
| tmr2_gate | output | 1 | Timer channel 2 gate |
| spkr_data | output | 1 | Speaker data enable |
| kbd_clk_hold | output | 1 | Drive keyboard clock low when 1 |
| irq1 | output | 1 | Keyboard interrupt request |

## Verification
The following are checked by assertions on every cycle:
- The keyboard clock is held while IRQ1 is pending.
- A clear bit drops IRQ1 on the next cycle.
- A held byte stays stable until cleared.
- Parity flags stay sticky while enabled and clear when disabled.
- A control-byte write reaches the timer gate.

The following can only be shown by the bench scenarios:
- The serial framing: start bit, LSB-first order and the ninth-edge completion.
- The selection of switch nibbles and port A sources in both layouts.
- The ignoring of strobes while masked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW = 8;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    // control byte, bit 7 first
    typedef struct packed {
        logic kbd_clear;   // 7
        logic kbd_clk_rel; // 6
        logic io_chk_n;    // 5
        logic mb_chk_n;    // 4
        logic nib_hi;      // 3
        logic sw2_wide;    // 2
        logic spk_data;    // 1
        logic tmr_gate;    // 0
    } ctl_t;

    typedef struct packed {
        logic       mb_err;
        logic       io_err;
        logic       tmr_mon;
        logic       spk_mon;
        logic [3:0] sw_nib;
    } portc_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FULL  = 2'd2
    } rx_state_e;

    function automatic logic [3:0] pick_nib(input logic [7:0] sw, input logic hi);
        return hi ? sw[7:4] : sw[3:0];
    endfunction

    function automatic logic [3:0] sw2_nib(input logic [4:0] sw, input logic wide);
        return wide ? sw[3:0] : {3'b111, sw[4]};
    endfunction

endpackage

// File: rtl/sysctl_ctl_reg.sv
module sysctl_ctl_reg
    import sysctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  logic [DW-1:0] d,
    output ctl_t   q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= ctl_t'(d);
    end
endmodule

// File: rtl/sysctl_kbd_rx.sv
module sysctl_kbd_rx
    import sysctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NBITS       = DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             kbd_clk_i,
    input  logic             kbd_data_i,
    output logic [NBITS-1:0] byte_q,
    output logic             irq
);
    localparam int CW = (NBITS > 1) ? $clog2(NBITS) : 1;

    logic [SYNC_STAGES:0]   clk_sh;
    logic [SYNC_STAGES-1:0] dat_sh;
    logic                   fall;
    logic                   bit_in;
    rx_state_e              state;
    logic [CW-1:0]          cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh <= '1;
            dat_sh <= '1;
        end else begin
            clk_sh <= {clk_sh[SYNC_STAGES-1:0], kbd_clk_i};
            dat_sh <= {dat_sh[SYNC_STAGES-2:0], kbd_data_i};
        end
    end

    assign fall   = clk_sh[SYNC_STAGES] & ~clk_sh[SYNC_STAGES-1];
    assign bit_in = dat_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            byte_q <= '0;
        end else if (fall) begin
            case (state)
                RX_IDLE: begin
                    if (bit_in) begin
                        state <= RX_SHIFT;
                        cnt   <= '0;
                    end
                end
                RX_SHIFT: begin
                    byte_q <= {bit_in, byte_q[NBITS-1:1]};
                    cnt    <= cnt + 1'b1;
                    if (cnt == CW'(NBITS - 1))
                        state <= RX_FULL;
                end
                default: state <= RX_FULL;
            endcase
        end
    end

    assign irq = (state == RX_FULL);
endmodule

// File: rtl/sysctl_par_latch.sv
module sysctl_par_latch (
    input  logic clk,
    input  logic rst,
    input  logic en_n,
    input  logic strobe,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || en_n)
            flag <= 1'b0;
        else if (strobe)
            flag <= 1'b1;
    end
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
    import sysctl_pkg::*;
#(
    parameter bit EARLY_LAYOUT = 1'b0
) (
    input  logic [1:0]    sel,
    input  ctl_t          ctl,
    input  logic [DW-1:0] kbd_byte,
    input  logic [7:0]    sw1,
    input  logic [4:0]    sw2,
    input  logic          tmr2_out,
    input  logic          spkr_mon,
    input  logic          flag_mb,
    input  logic          flag_io,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] port_a;
    portc_t        port_c;

    always_comb begin
        if (EARLY_LAYOUT && ctl.kbd_clear)
            port_a = sw1;
        else
            port_a = kbd_byte;

        port_c.mb_err  = flag_mb;
        port_c.io_err  = flag_io;
        port_c.tmr_mon = tmr2_out;
        port_c.spk_mon = spkr_mon;
        port_c.sw_nib  = EARLY_LAYOUT ? sw2_nib(sw2, ctl.sw2_wide)
                                      : pick_nib(sw1, ctl.nib_hi);
    end

    always_comb begin
        case (port_sel_e'(sel))
            SEL_A:   rd = port_a;
            SEL_B:   rd = ctl;
            SEL_C:   rd = port_c;
            default: rd = '0;
        endcase
    end
endmodule

// File: rtl/pc_sysctl_port.sv
module pc_sysctl_port
    import sysctl_pkg::*;
#(
    parameter bit EARLY_LAYOUT = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [7:0] sw1,
    input  logic [4:0] sw2,
    input  logic       tmr2_out,
    input  logic       spkr_mon,
    input  logic       par_err_mb,
    input  logic       par_err_io,
    input  logic       kbd_clk_i,
    input  logic       kbd_data_i,
    output logic       tmr2_gate,
    output logic       spkr_data,
    output logic       kbd_clk_hold,
    output logic       irq1
);
    ctl_t          ctl_q;
    logic [DW-1:0] kbd_byte;
    logic          flag_mb;
    logic          flag_io;
    logic          ctl_we;

    assign ctl_we = wr_en && (port_sel_e'(sel) == SEL_B);

    sysctl_ctl_reg u_ctl (
        .clk (clk),
        .rst (rst),
        .we  (ctl_we),
        .d   (wr_data),
        .q   (ctl_q)
    );

    sysctl_kbd_rx #(.SYNC_STAGES(SYNC_STAGES), .NBITS(DW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (ctl_q.kbd_clear),
        .kbd_clk_i  (kbd_clk_i),
        .kbd_data_i (kbd_data_i),
        .byte_q     (kbd_byte),
        .irq        (irq1)
    );

    logic [1:0] par_en_n;
    logic [1:0] par_strobe;
    logic [1:0] par_flag;

    assign par_en_n   = {ctl_q.io_chk_n, ctl_q.mb_chk_n};
    assign par_strobe = {par_err_io, par_err_mb};

    for (genvar g = 0; g < 2; g++) begin : g_par
        sysctl_par_latch u_lat (
            .clk    (clk),
            .rst    (rst),
            .en_n   (par_en_n[g]),
            .strobe (par_strobe[g]),
            .flag   (par_flag[g])
        );
    end

    assign flag_mb = par_flag[0];
    assign flag_io = par_flag[1];

    sysctl_rd_mux #(.EARLY_LAYOUT(EARLY_LAYOUT)) u_mux (
        .sel      (sel),
        .ctl      (ctl_q),
        .kbd_byte (kbd_byte),
        .sw1      (sw1),
        .sw2      (sw2),
        .tmr2_out (tmr2_out),
        .spkr_mon (spkr_mon),
        .flag_mb  (flag_mb),
        .flag_io  (flag_io),
        .rd       (rd_data)
    );

    assign tmr2_gate    = ctl_q.tmr_gate;
    assign spkr_data    = ctl_q.spk_data;
    assign kbd_clk_hold = ~ctl_q.kbd_clk_rel | irq1;
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ctl,
    input logic       irq1,
    input logic       kbd_clk_hold,
    input logic [7:0] kbd_byte,
    input logic       flag_mb,
    input logic       flag_io,
    input logic       wr_en,
    input logic [1:0] sel,
    input logic [7:0] wr_data,
    input logic       tmr2_gate
);
    // R6
    clk_hold_on_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq1 |-> kbd_clk_hold);

    // R9
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
        ctl[7] |=> !irq1);

    // R8
    byte_held_chk: assert property (@(posedge clk) disable iff (rst)
        (irq1 && !ctl[7]) |=> $stable(kbd_byte));

    // R10
    mb_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl[4] |=> !flag_mb);

    // R10
    io_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ctl[5] |=> !flag_io);

    // R10
    mb_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_mb && !ctl[4] && !(wr_en && sel == 2'd1)) |=> flag_mb);

    // R2
    gate_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 2'd1) |=> (tmr2_gate == $past(wr_data[0])));
endmodule

bind pc_sysctl_port sysctl_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl_q),
    .irq1         (irq1),
    .kbd_clk_hold (kbd_clk_hold),
    .kbd_byte     (kbd_byte),
    .flag_mb      (flag_mb),
    .flag_io      (flag_io),
    .wr_en        (wr_en),
    .sel          (sel),
    .wr_data      (wr_data),
    .tmr2_gate    (tmr2_gate)
);

// File: tb/tb_pc_sysctl_port.sv
`timescale 1ns/1ps
module tb_pc_sysctl_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sw1 = 8'h00;
    logic [4:0] sw2 = 5'h00;
    logic       tmr2_out = 1'b0, spkr_mon = 1'b0;
    logic       par_err_mb = 1'b0, par_err_io = 1'b0;
    logic       kbd_clk_i = 1'b1, kbd_data_i = 1'b1;

    logic [7:0] rd0, rd1;
    logic       gate0, spk0, hold0, irq0;
    logic       gate1, spk1, hold1, irq1b;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // model state
    logic [7:0] m_ctl = 8'h00;
    logic [7:0] m_byte = 8'h00;
    logic       m_irq = 1'b0;
    logic       m_fmb = 1'b0, m_fio = 1'b0;

    always #2.5 clk = ~clk;

    pc_sysctl_port #(.EARLY_LAYOUT(1'b0)) dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd0), .sw1(sw1), .sw2(sw2), .tmr2_out(tmr2_out),
        .spkr_mon(spkr_mon), .par_err_mb(par_err_mb), .par_err_io(par_err_io),
        .kbd_clk_i(kbd_clk_i), .kbd_data_i(kbd_data_i), .tmr2_gate(gate0),
        .spkr_data(spk0), .kbd_clk_hold(hold0), .irq1(irq0));

    pc_sysctl_port #(.EARLY_LAYOUT(1'b1)) dut_alt (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd1), .sw1(sw1), .sw2(sw2), .tmr2_out(tmr2_out),
        .spkr_mon(spkr_mon), .par_err_mb(par_err_mb), .par_err_io(par_err_io),
        .kbd_clk_i(kbd_clk_i), .kbd_data_i(kbd_data_i), .tmr2_gate(gate1),
        .spkr_data(spk1), .kbd_clk_hold(hold1), .irq1(irq1b));

    function automatic logic [7:0] exp_c(input bit early);
        logic [3:0] nib;
        if (early) nib = m_ctl[2] ? sw2[3:0] : {3'b111, sw2[4]};
        else       nib = m_ctl[3] ? sw1[7:4] : sw1[3:0];
        return {m_fmb, m_fio, tmr2_out, spkr_mon, nib};
    endfunction

    function automatic logic [7:0] exp_a(input bit early);
        if (early && m_ctl[7]) return sw1;
        return m_byte;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic rd_port(input logic [1:0] s, output logic [7:0] v0, output logic [7:0] v1);
        @(negedge clk);
        sel = s;
        #1;
        v0 = rd0;
        v1 = rd1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        sel = 2'd1; wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_ctl = v;
        if (v[7]) begin m_byte = 8'h00; m_irq = 1'b0; end
        if (v[4]) m_fmb = 1'b0;
        if (v[5]) m_fio = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b);
        for (int i = 0; i < 9; i++) begin
            kbd_data_i = (i == 0) ? 1'b1 : b[i-1];
            repeat (4) @(negedge clk);
            kbd_clk_i = 1'b0;
            repeat (4) @(negedge clk);
            kbd_clk_i = 1'b1;
            repeat (4) @(negedge clk);
        end
        kbd_data_i = 1'b1;
    endtask

    task automatic pulse(input bit io);
        @(negedge clk);
        if (io) par_err_io = 1'b1; else par_err_mb = 1'b1;
        @(negedge clk);
        par_err_io = 1'b0; par_err_mb = 1'b0;
        if (io && !m_ctl[5]) m_fio = 1'b1;
        if (!io && !m_ctl[4]) m_fmb = 1'b1;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] a0, a1;
        rd_port(2'd0, a0, a1);
        check({tag, " R4 port A"}, a0, exp_a(1'b0));
        check({tag, " R5 port A"}, a1, exp_a(1'b1));
        rd_port(2'd1, a0, a1);
        check({tag, " R2 port B"}, a0, m_ctl);
        rd_port(2'd2, a0, a1);
        check({tag, " R4 R3 R10 port C"}, a0, exp_c(1'b0));
        check({tag, " R5 R3 R10 port C"}, a1, exp_c(1'b1));
        rd_port(2'd3, a0, a1);
        check({tag, " R2 unused select"}, a0, 8'h00);
        check({tag, " R2 gate/speaker"}, {6'd0, spk0, gate0}, m_ctl[1:0]);
        check({tag, " R6 clk hold"}, {7'd0, hold0}, {7'd0, ~m_ctl[6] | m_irq});
        check({tag, " R7 irq1"}, {7'd0, irq0}, {7'd0, m_irq});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v0, v1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_all("R1 reset");

        // R7 receive a frame
        wr_ctl(8'h40);
        send_frame(8'hA5);
        m_byte = 8'hA5; m_irq = 1'b1;
        check_all("R7 frame");

        // R8 further frame ignored while irq pending
        send_frame(8'h3C);
        check_all("R8 ignored frame");

        // R9 clear by control bit 7
        wr_ctl(8'hC0);
        check_all("R9 clear");
        send_frame(8'h77);
        check_all("R9 held idle");
        wr_ctl(8'h40);
        send_frame(8'h81);
        m_byte = 8'h81; m_irq = 1'b1;
        check_all("R7 second frame");
        wr_ctl(8'hC0);
        wr_ctl(8'h40);

        // R10 parity latches
        pulse(1'b0);
        check_all("R10 mb set");
        repeat (5) @(negedge clk);
        check_all("R10 mb sticky");
        wr_ctl(8'h50);
        check_all("R10 mb cleared");
        pulse(1'b0);
        check_all("R10 mb masked strobe");
        pulse(1'b1);
        check_all("R10 io set");
        wr_ctl(8'h70);
        pulse(1'b1);
        check_all("R10 io masked strobe");
        wr_ctl(8'h40);

        // random mix: R2 R3 R4 R5 R6
        for (int k = 0; k < 60; k++) begin
            sw1 = 8'($urandom);
            sw2 = 5'($urandom);
            tmr2_out = 1'($urandom);
            spkr_mon = 1'($urandom);
            wr_ctl(8'($urandom));
            if (k % 7 == 0) pulse(1'($urandom));
            check_all("rand");
        end

        rd_port(2'd1, v0, v1);
        check("R2 final readback alt", v1, m_ctl);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule